// File: doc/BRIEF.md
# Serial-Load Bank Register Unit

This block holds four 5-bit configuration registers that the CPU fills one bit at a time. Each write into the upper half of the address space (address bit 15 set) either shifts data bit 0 into a staging buffer or, when data bit 7 is set, restarts the sequence. The fifth shifted write moves the staged value into the register chosen by address bits 14:13.

From the four registers the block forms the outputs that the memory system uses. These are two 16 KB program-bank numbers, for the windows at 0x8000 and 0xC000. There are also two 4 KB pattern-bank numbers and a 2-bit nametable mirroring code. The outputs follow the register contents combinationally, so a committed write shows on the outputs right after the clock edge that captures it.

Top module: `serial_bank_cfg`

## Requirements
- R1: A write with address bit 15 set and data bit 7 clear adds data bit 0 to the staging buffer, first write at bit 0. Data bits 6:1 have no effect on any register.
- R2: The fifth such write commits to register number address bits 14:13. The final write's data bit 0 becomes bit 4 of that register. The buffer and count are then empty, so the next write starts a new sequence.
- R3: A write with address bit 15 and data bit 7 set drops any partial sequence and sets bits 3 and 2 of register 0, keeping its other bits.
- R4: After reset, register 0 holds 0x0C and registers 1 to 3 hold 0. The outputs are then: program low 0, program high 0xF, pattern low 0, pattern high 1, mirroring 0.
- R5: With register 0 bit 3 clear (32 KB mode), the program low output is register 3 bits 3:0 with bit 0 cleared, and the program high output is the same value with bit 0 set.
- R6: With register 0 bit 3 set, bit 2 set gives program low = register 3 bits 3:0 and program high = 0xF. Bit 2 clear gives program low = 0 and program high = register 3 bits 3:0.
- R7: With register 0 bit 4 set, the pattern low and high outputs are registers 1 and 2. With bit 4 clear, they are register 1 with bit 0 cleared and register 1 with bit 0 set.
- R8: The mirroring output equals register 0 bits 1:0. The encoding is 0 single-screen low, 1 single-screen high, 2 vertical, 3 horizontal.
- R9: Writes with address bit 15 clear change no register and no sequence state. This holds even when data bit 7 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| prg_lo | output | 4 | 16 KB program bank for the 0x8000 window |
| prg_hi | output | 4 | 16 KB program bank for the 0xC000 window |
| chr_lo | output | 5 | 4 KB pattern bank for the lower half |
| chr_hi | output | 5 | 4 KB pattern bank for the upper half |
| mirror | output | 2 | Nametable mirroring code |

## Verification
The assertions assume that each CPU write appears as exactly one cycle of `wr_en`, already filtered so that back-to-back bus writes do not reach the block twice. The bench drives every write as a single-cycle pulse with an idle cycle after it, so this holds. Address and data are held stable while the strobe is high, and reset is released only between writes. Out-of-range addresses and reset-bit writes are deliberately placed in the middle of partial sequences to test the count handling.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
    localparam int REG_W    = 5;
    localparam int NUM_REGS = 4;
    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 8;
    localparam int PRG_W    = 4;
    localparam int SEL_W    = $clog2(NUM_REGS);
    localparam int CNT_W    = $clog2(REG_W + 1);
    localparam int STG_W    = REG_W - 1;
    localparam int IDX_W    = $clog2(STG_W);
    localparam int SEL_LSB  = 13;

    localparam logic [REG_W-1:0] CTRL_INIT = 5'h0C;

    typedef logic [REG_W-1:0]               cfg_reg_t;
    typedef cfg_reg_t [NUM_REGS-1:0]        cfg_bank_t;

    typedef struct packed {
        logic [STG_W-1:0] stage;
        logic [CNT_W-1:0] cnt;
        cfg_bank_t        regs;
    } loader_st_t;

    typedef enum logic [1:0] {
        MIR_ONE_LO = 2'd0,
        MIR_ONE_HI = 2'd1,
        MIR_VERT   = 2'd2,
        MIR_HORZ   = 2'd3
    } mirror_e;
endpackage

// File: rtl/serial_loader.sv
module serial_loader
    import sercfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output cfg_bank_t         regs_o
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(REG_W - 1);

    loader_st_t st_d, st_q;
    logic       hit;
    logic [SEL_W-1:0] sel;

    assign hit = wr_en && wr_addr[ADDR_W-1];
    assign sel = wr_addr[SEL_LSB +: SEL_W];

    always_comb begin
        st_d = st_q;
        if (hit) begin
            if (wr_data[DATA_W-1]) begin
                st_d.stage   = '0;
                st_d.cnt     = '0;
                st_d.regs[0] = st_q.regs[0] | CTRL_INIT;
            end else if (st_q.cnt == LAST_CNT) begin
                st_d.regs[sel] = {wr_data[0], st_q.stage};
                st_d.stage     = '0;
                st_d.cnt       = '0;
            end else begin
                st_d.stage[st_q.cnt[IDX_W-1:0]] = wr_data[0];
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.stage <= '0;
            st_q.cnt   <= '0;
            for (int i = 0; i < NUM_REGS; i++)
                st_q.regs[i] <= (i == 0) ? CTRL_INIT : '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign regs_o = st_q.regs;

    // R1
    shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !wr_data[DATA_W-1] && st_q.cnt != LAST_CNT)
        |=> (st_q.cnt == $past(st_q.cnt) + 1'b1) && $stable(st_q.regs));

    // R2
    commit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !wr_data[DATA_W-1] && st_q.cnt == LAST_CNT)
        |=> (st_q.cnt == '0) && (st_q.stage == '0));

    // R3
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && wr_data[DATA_W-1])
        |=> (st_q.cnt == '0) && (st_q.regs[0][3:2] == 2'b11));

    // R9
    ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(st_q));
endmodule

// File: rtl/bank_map.sv
module bank_map
    import sercfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  cfg_bank_t        regs_i,
    output logic [PRG_W-1:0] prg_lo_o,
    output logic [PRG_W-1:0] prg_hi_o,
    output logic [REG_W-1:0] chr_lo_o,
    output logic [REG_W-1:0] chr_hi_o,
    output mirror_e          mirror_o
);
    localparam logic [PRG_W-1:0] FIXED_TOP = '1;

    cfg_reg_t         ctrl;
    logic [PRG_W-1:0] bank;

    assign ctrl = regs_i[0];
    assign bank = regs_i[3][PRG_W-1:0];

    always_comb begin
        if (!ctrl[3]) begin
            prg_lo_o = {bank[PRG_W-1:1], 1'b0};
            prg_hi_o = {bank[PRG_W-1:1], 1'b1};
        end else if (ctrl[2]) begin
            prg_lo_o = bank;
            prg_hi_o = FIXED_TOP;
        end else begin
            prg_lo_o = '0;
            prg_hi_o = bank;
        end

        if (ctrl[4]) begin
            chr_lo_o = regs_i[1];
            chr_hi_o = regs_i[2];
        end else begin
            chr_lo_o = {regs_i[1][REG_W-1:1], 1'b0};
            chr_hi_o = {regs_i[1][REG_W-1:1], 1'b1};
        end

        mirror_o = mirror_e'(ctrl[1:0]);
    end

    // R5
    pair_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !regs_i[0][3] |-> (!prg_lo_o[0] && prg_hi_o[0]
                           && prg_lo_o[PRG_W-1:1] == prg_hi_o[PRG_W-1:1]));

    // R6
    fixed_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_i[0][3] && regs_i[0][2]) |-> (prg_hi_o == FIXED_TOP));

    // R6
    fixed_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_i[0][3] && !regs_i[0][2]) |-> (prg_lo_o == '0));
endmodule

// File: rtl/serial_bank_cfg.sv
module serial_bank_cfg
    import sercfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [PRG_W-1:0]  prg_lo,
    output logic [PRG_W-1:0]  prg_hi,
    output logic [REG_W-1:0]  chr_lo,
    output logic [REG_W-1:0]  chr_hi,
    output logic [1:0]        mirror
);
    cfg_bank_t regs;
    mirror_e   mir;

    serial_loader u_loader (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .regs_o  (regs)
    );

    bank_map u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .regs_i   (regs),
        .prg_lo_o (prg_lo),
        .prg_hi_o (prg_hi),
        .chr_lo_o (chr_lo),
        .chr_hi_o (chr_hi),
        .mirror_o (mir)
    );

    assign mirror = mir;

    // R8
    mirror_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mirror == regs[0][1:0]);
endmodule

// File: tb/sim_serial_bank_cfg.sv
`timescale 1ns/1ps
module sim_serial_bank_cfg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [3:0]  prg_lo, prg_hi;
    logic [4:0]  chr_lo, chr_hi;
    logic [1:0]  mirror;

    always #5 clk = ~clk;

    serial_bank_cfg u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .prg_lo(prg_lo), .prg_hi(prg_hi),
        .chr_lo(chr_lo), .chr_hi(chr_hi), .mirror(mirror)
    );

    typedef struct {
        logic [19:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    logic [4:0] m_reg [4];
    logic [4:0] m_buf;
    int         m_cnt;

    function automatic logic [19:0] expect_out();
        logic [3:0] b, lo, hi;
        logic [4:0] cl, ch;
        b = m_reg[3][3:0];
        if (!m_reg[0][3]) begin lo = b & 4'hE; hi = b | 4'h1; end
        else if (m_reg[0][2]) begin lo = b; hi = 4'hF; end
        else begin lo = 4'h0; hi = b; end
        if (m_reg[0][4]) begin cl = m_reg[1]; ch = m_reg[2]; end
        else begin cl = m_reg[1] & 5'h1E; ch = m_reg[1] | 5'h01; end
        return {lo, hi, cl, ch, m_reg[0][1:0]};
    endfunction

    task automatic push(input string tag);
        item_t it;
        it.exp = expect_out();
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        if (!a[15]) return;
        if (d[7]) begin
            m_buf = '0; m_cnt = 0; m_reg[0] = m_reg[0] | 5'h0C;
        end else begin
            m_buf[m_cnt] = d[0];
            m_cnt++;
            if (m_cnt == 5) begin
                m_reg[a[14:13]] = m_buf; m_buf = '0; m_cnt = 0;
            end
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
        model_write(a, d);
        push(tag);
    endtask

    task automatic load(input int idx, input logic [4:0] v, input string tag);
        for (int i = 0; i < 5; i++)
            wr(16'h8000 + 16'(idx) * 16'h2000, {7'h00, v[i]}, tag);
    endtask

    // monitor: pops expected items and compares against the outputs
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                item_t it;
                logic [19:0] act;
                it = q.pop_front();
                act = {prg_lo, prg_hi, chr_lo, chr_hi, mirror};
                compared++;
                if (act !== it.exp) begin
                    mismatched++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        m_reg[0] = 5'h0C; m_reg[1] = '0; m_reg[2] = '0; m_reg[3] = '0;
        m_buf = '0; m_cnt = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        push("R4 reset state");

        load(3, 5'h07, "R1 R2 R6 load bank 7");
        load(0, 5'h00, "R5 R8 pair mode");
        load(0, 5'h08, "R6 bit2 clear");
        load(1, 5'h13, "R2 load reg1");
        load(2, 5'h05, "R2 load reg2");
        load(0, 5'h1E, "R7 R8 separate pattern banks");
        load(0, 5'h10, "R2 last bit lands at bit4");
        load(0, 5'h03, "R7 R8 paired pattern banks");

        // R1: upper data bits must not matter; value 0x0B built with noise
        wr(16'hE000, 8'h7F, "R1 noise bit0=1");
        wr(16'hE123, 8'h41, "R1 noise bit1=1");
        wr(16'hE000, 8'h7E, "R1 noise bit2=0");
        wr(16'hFFFF, 8'h03, "R1 noise bit3=1");
        wr(16'hE000, 8'h2A, "R1 noise bit4=0");

        // R3: partial sequence then restart bit
        wr(16'h8000, 8'h01, "R3 partial");
        wr(16'h8000, 8'h01, "R3 partial");
        wr(16'h9000, 8'h80, "R3 restart sets bits 3:2");
        load(0, 5'h01, "R3 count restarted, R8 mirror 1");

        // R9: out-of-range writes mid-sequence, including restart bit
        wr(16'hC000, 8'h00, "R9 seq");
        wr(16'h6000, 8'h01, "R9 low address ignored");
        wr(16'h7FFF, 8'h80, "R9 low address restart ignored");
        wr(16'hC000, 8'h01, "R9 seq");
        wr(16'hC000, 8'h01, "R9 seq");
        wr(16'hC000, 8'h00, "R9 seq");
        wr(16'hC000, 8'h01, "R9 reg2 committed after five");
        load(0, 5'h1C, "R7 R8 reg2 value 0x16");

        repeat (4) @(posedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule